// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block makes a two-wire I2C bus see a small byte-addressed serial EEPROM. A fast system clock oversamples the clock and data lines. The block finds start, repeated-start and stop conditions on those samples. It answers to a 7-bit device address. That address joins a fixed device-type nibble to three chip-select bits, and the three bits come from a static strap, so up to eight such targets can share one bus.

Two transactions are served. A single-byte write sends the device address with the write flag, then a word address, then one data byte. The data byte lands in storage at that word address. A random read is a dummy write that carries only the word address. A repeated start follows, then the device address with the read flag. The target then shifts out the stored byte, most significant bit first. The data line is open-drain: the block only pulls it low or lets it go, and the pull-up outside the block supplies the high level.

Top module: `i2cEepromTarget`

## Requirements
- R1: A fall on the data line while the clock line is high is a START. From any state, a START opens a fresh device-address byte. A rise on the data line while the clock is high is a STOP. A STOP returns the block to idle with the data line released.
- R2: The first byte after a START is taken MSB first. Bits 7:4 must be 1010 and bits 3:1 must equal the chip-select strap. Bit 0 is the direction: 0 means write, 1 means read. When both fields match, the byte is acknowledged.
- R3: If either address field differs, the target gives no acknowledge. It then ignores every bit until the next START or STOP, and its storage is left unchanged.
- R4: The acknowledge pulls the data line low for the whole ninth clock of an accepted byte. It is released after that clock's falling edge.
- R5: In a write, the word-address byte and one data byte are each acknowledged. The data byte is then stored at the word address.
- R6: In a random read, the target shifts out the byte stored at the word address given in the preceding dummy write, MSB first, one bit per clock.
- R7: The target changes its pull on the data line only while the clock line is low.
- R8: After the eighth read data bit the target releases the data line. Until the next START or STOP, further clocks read back all ones.
- R9: After reset every storage location reads 0x00.
- R10: A write accepts exactly one data byte. A further byte before the STOP gets no acknowledge and is not stored anywhere.
- R11: A START or STOP in the middle of a byte abandons the partial byte. An address byte sent after it is handled as a fresh one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| chipSel | input | 3 | Static strap matched against address bits 3:1 |
| sdaPullLow | output | 1 | When 1, the pin driver pulls the data line low |

## Verification
A bus event and a byte-level action can fall in the same cycle. The start or stop detector can fire while a byte is only partly shifted in, and that event must win over the bit counter and the pending acknowledge. The bench provokes this with a repeated START and with a STOP sent after only a few bits of a byte. It then sends a full write, and the block must acknowledge all of it and later read the stored value back. A second such pair is the release of the device-address acknowledge and the loading of the first read bit, which share one clock edge. This is judged by checking that the read byte arrives whole and in the right bit order, and that the pull on the data line never changes while the clock is high.

// File: rtl/i2cEepPkg.sv
package i2cEepPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WORD,
    PH_DATA,
    PH_READ,
    PH_HOLD
  } phaseT;

  typedef struct packed {
    logic shiftIn;
    logic loadWord;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
  } dpStrobeT;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sclPrev,
  output logic sdaS,
  output logic sdaPrev
);
  localparam int LAST = STAGES;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
    end
  end

  assign sclS    = sclPipe[LAST-1];
  assign sclPrev = sclPipe[LAST];
  assign sdaS    = sdaPipe[LAST-1];
  assign sdaPrev = sdaPipe[LAST];

endmodule

// File: rtl/i2cDatapath.sv
module i2cDatapath
  import i2cEepPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wordPtr;
  logic [BYTE_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) store[k] <= '0;
    end else if (stb.writeMem) begin
      store[wordPtr] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      wordPtr <= '0;
      txReg   <= '1;
    end else begin
      if (stb.shiftIn)  rxByte  <= {rxByte[BYTE_W-2:0], sdaBit};
      if (stb.loadWord) wordPtr <= ADDR_W'(rxByte);
      if (stb.loadTx)        txReg <= store[wordPtr];
      else if (stb.shiftTx)  txReg <= {txReg[BYTE_W-2:0], 1'b1};
    end
  end

  assign txMsb = txReg[BYTE_W-1];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.loadWord, stb.writeMem, stb.loadTx, stb.shiftTx})); // R5

  AST_LOAD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |=> $stable(wordPtr)); // R6

endmodule

// File: rtl/i2cCtl.sv
module i2cCtl
  import i2cEepPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sclPrev,
  input  logic              sdaS,
  input  logic              sdaPrev,
  input  logic [2:0]        chipSel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpStrobeT          stb,
  output logic              sdaPullLow
);
  phaseT      phase, phaseN, ackNext, ackNextN;
  logic [3:0] bitCnt, bitCntN;
  logic       ackOn, ackOnN;

  logic startEv, stopEv, sclRise, sclFall, devHit;

  assign startEv = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopEv  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise = sclS && !sclPrev;
  assign sclFall = !sclS && sclPrev;
  assign devHit  = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == chipSel);

  always_comb begin
    phaseN   = phase;
    bitCntN  = bitCnt;
    ackOnN   = ackOn;
    ackNextN = ackNext;
    stb      = '0;
    if (startEv) begin
      phaseN  = PH_DEV;
      bitCntN = '0;
      ackOnN  = 1'b0;
    end else if (stopEv) begin
      phaseN  = PH_IDLE;
      bitCntN = '0;
      ackOnN  = 1'b0;
    end else begin
      case (phase)
        PH_DEV, PH_WORD, PH_DATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            bitCntN     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = 4'd9;
            case (phase)
              PH_DEV: begin
                if (devHit) begin
                  ackOnN   = 1'b1;
                  ackNextN = rxByte[0] ? PH_READ : PH_WORD;
                end else begin
                  phaseN  = PH_IDLE;
                  bitCntN = '0;
                end
              end
              PH_WORD: begin
                ackOnN       = 1'b1;
                ackNextN     = PH_DATA;
                stb.loadWord = 1'b1;
              end
              default: begin
                ackOnN       = 1'b1;
                ackNextN     = PH_HOLD;
                stb.writeMem = 1'b1;
              end
            endcase
          end else if (sclFall && bitCnt == 4'd9) begin
            ackOnN     = 1'b0;
            bitCntN    = '0;
            phaseN     = ackNext;
            stb.loadTx = (ackNext == PH_READ);
          end
        end
        PH_READ: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            phaseN  = PH_HOLD;
            bitCntN = '0;
          end else if (sclFall && bitCnt != 4'd0) begin
            stb.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      ackNext <= PH_IDLE;
      bitCnt  <= '0;
      ackOn   <= 1'b0;
    end else begin
      phase   <= phaseN;
      ackNext <= ackNextN;
      bitCnt  <= bitCntN;
      ackOn   <= ackOnN;
    end
  end

  assign sdaPullLow = ackOn || (phase == PH_READ && !txMsb);

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (phase == PH_DEV && bitCnt == 4'd0 && !ackOn)); // R1

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (phase == PH_IDLE && !sdaPullLow)); // R1

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE || phase == PH_HOLD) |-> !sdaPullLow); // R3

  AST_ACK_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOn) |-> (!sclS && $past(bitCnt) == 4'd8)); // R4

  AST_PULL_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclPrev) |-> $stable(sdaPullLow)); // R7

endmodule

// File: rtl/i2cEepromTarget.sv
module i2cEepromTarget
  import i2cEepPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  output logic       sdaPullLow
);
  logic              sclS, sclPrev, sdaS, sdaPrev, txMsb;
  logic [BYTE_W-1:0] rxByte;
  dpStrobeT          stb;

  i2cLineSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sclPrev(sclPrev), .sdaS(sdaS), .sdaPrev(sdaPrev)
  );

  i2cCtl i_ctl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclPrev(sclPrev),
    .sdaS(sdaS), .sdaPrev(sdaPrev), .chipSel(chipSel),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaPullLow(sdaPullLow)
  );

  i2cDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaS),
    .rxByte(rxByte), .txMsb(txMsb)
  );

endmodule

// File: tb/test_i2cEepromTarget.sv
module test_i2cEepromTarget;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mPull = 1'b0;
  logic [2:0] chipSel = 3'b101;
  logic       sdaPullLow;
  logic       sdaLine;

  assign sdaLine = !(mPull || sdaPullLow);

  always #2 clk = ~clk;

  i2cEepromTarget i_i2cEepromTarget (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .chipSel(chipSel), .sdaPullLow(sdaPullLow)
  );

  int nRun = 0;
  int nFail = 0;
  int viol = 0;

  typedef struct {
    string tag;
    int    val;
  } expT;
  expT  expQ[$];
  event obsEv;
  int   obsVal;

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(string tag, int v);
    expT e;
    e.tag = tag;
    e.val = v;
    expQ.push_back(e);
  endtask

  task automatic report(int v);
    obsVal = v;
    ->obsEv;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) check("scoreboard underflow", 1, 0);
      else begin
        expT e;
        e = expQ.pop_front();
        check(e.tag, obsVal, e.val);
      end
    end
  end

  // R7 watcher: the pull must not move while the raw clock stays high
  logic prevScl = 1'b1, prevPull = 1'b0;
  always @(negedge clk) begin
    if (rstN && scl && prevScl && (sdaPullLow !== prevPull)) viol++;
    prevScl  = scl;
    prevPull = sdaPullLow;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mPull = 1'b0; waitQ();
    scl = 1'b1;   waitQ();
    mPull = 1'b1; waitQ();
    scl = 1'b0;   waitQ();
  endtask

  task automatic busStop();
    mPull = 1'b1; waitQ();
    scl = 1'b1;   waitQ();
    mPull = 1'b0; waitQ();
  endtask

  task automatic sendBit(logic b);
    mPull = !b; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    mPull = 1'b0; waitQ();
    scl = 1'b1;   waitQ();
    b = sdaLine;  waitQ();
    scl = 1'b0;   waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, string tag, int ackExp);
    logic a;
    pushExp(tag, ackExp);
    for (int k = 7; k >= 0; k--) sendBit(v[k]);
    getBit(a);
    report(int'(!a));
  endtask

  task automatic readByte(string tag, logic [7:0] expV);
    logic [7:0] v;
    logic       b;
    pushExp(tag, int'(expV));
    for (int k = 7; k >= 0; k--) begin
      getBit(b);
      v[k] = b;
    end
    sendBit(1'b1);
    report(int'(v));
  endtask

  function automatic logic [7:0] devByte(logic rd);
    return {4'b1010, chipSel, rd};
  endfunction

  task automatic doWrite(logic [7:0] a, logic [7:0] d, string tag);
    busStart();
    sendByte(devByte(1'b0), {tag, " R2 dev ack"}, 1);
    sendByte(a, {tag, " R5 word ack"}, 1);
    sendByte(d, {tag, " R5 data ack"}, 1);
    pushExp("R4 ack released", 1);
    report(int'(sdaLine));
    busStop();
  endtask

  task automatic doRead(logic [7:0] a, logic [7:0] expV, string tag);
    busStart();
    sendByte(devByte(1'b0), {tag, " R2 dummy dev ack"}, 1);
    sendByte(a, {tag, " R6 word ack"}, 1);
    busStart();
    sendByte(devByte(1'b1), {tag, " R2 read dev ack"}, 1);
    readByte({tag, " R6 read data"}, expV);
    busStop();
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 reset state released", int'(sdaPullLow), 0);

    doWrite(8'h12, 8'h3C, "wr12");
    doRead(8'h12, 8'h3C, "rd12");
    doRead(8'h80, 8'h00, "R9 untouched location");
    doWrite(8'h07, 8'h81, "wr07");
    doWrite(8'h08, 8'h7E, "wr08");
    doRead(8'h07, 8'h81, "rd07");
    doRead(8'h08, 8'h7E, "rd08");

    // R3: chip-select mismatch, then bytes that must be ignored
    busStart();
    sendByte({4'b1010, 3'b011, 1'b0}, "R3 chip mismatch no ack", 0);
    sendByte(8'h12, "R3 ignored word byte", 0);
    sendByte(8'h55, "R3 ignored data byte", 0);
    busStop();
    // R3: wrong type nibble
    busStart();
    sendByte({4'b1011, chipSel, 1'b0}, "R3 type nibble mismatch no ack", 0);
    busStop();
    doRead(8'h12, 8'h3C, "R3 storage unchanged");

    // R10: an extra data byte in one write
    busStart();
    sendByte(devByte(1'b0), "R10 dev ack", 1);
    sendByte(8'hFF, "R10 word ack", 1);
    sendByte(8'hA5, "R10 data ack", 1);
    sendByte(8'h77, "R10 extra byte no ack", 0);
    busStop();
    doRead(8'hFF, 8'hA5, "R10 first byte stored");
    doRead(8'h00, 8'h00, "R10 extra byte not stored");

    // R11: repeated START after half an address byte
    busStart();
    for (int k = 7; k >= 4; k--) sendBit(devByte(1'b0)[k]);
    doWrite(8'h20, 8'h5A, "R11 after mid-byte start");
    doRead(8'h20, 8'h5A, "R11 start abort");

    // R11: STOP after three bits of the word byte
    busStart();
    sendByte(devByte(1'b0), "R11 dev ack before stop", 1);
    for (int k = 7; k >= 5; k--) sendBit(1'b1);
    busStop();
    doWrite(8'h21, 8'hC3, "R11 after mid-byte stop");
    doRead(8'h21, 8'hC3, "R11 stop abort");

    // R8: extra clocks after the master's no-acknowledge read all ones
    busStart();
    sendByte(devByte(1'b0), "R8 dummy dev ack", 1);
    sendByte(8'h07, "R8 word ack", 1);
    busStart();
    sendByte(devByte(1'b1), "R8 read dev ack", 1);
    readByte("R8 data byte", 8'h81);
    readByte("R8 released after nack", 8'hFF);
    busStop();
    check("R8 idle after stop", int'(sdaPullLow), 0);

    check("R7 pull change while clock high", viol, 0);
    check("R6 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule